// File: doc/BRIEF.md
# CCM Header Block Formatter

This block turns the scalar settings of one CCM operation into the header bytes that open the authentication pass. From the tag length, the size of the length field, the nonce and the payload length it builds the 16-byte first block. When there is associated data, it appends the encoded associated-data length after that block. The bytes leave on a valid/ready byte stream in transmit order, and the last byte is marked.

A single-cycle `start_i` captures every parameter while the block is idle. The block first checks that the payload length fits in the chosen number of length octets. If it does not, the block pulses an error and sends nothing. Otherwise it streams 16, 18 or 22 bytes and returns to idle. The cipher and the MAC arithmetic sit downstream and are not part of this block.

Top module: `ccm_hdr_formatter`

## Requirements
- R1: Byte 0 of the stream is the flags byte. Bit 7 is 0. Bit 6 is 1 exactly when `alen_i` is nonzero. Bits 5:3 hold (t-2)/2, where t is `tag_len_i`. Bits 2:0 hold q-1, where q is `q_len_i`.
- R2: Stream bytes 1 through 15-q carry the nonce. Stream byte 1+k is `nonce_i[8k+7:8k]`. Nonce bytes beyond index 14-q are not sent.
- R3: Stream bytes 16-q through 15 carry `plen_i` big-endian. Byte 15 is the least significant octet.
- R4: If `plen_i` is 2^(8q) or larger, `err_o` is high for exactly the one cycle after the accepting edge. `out_valid_o` stays low and the block stays idle.
- R5: When `alen_i` is zero, the stream is exactly 16 bytes and `out_last_o` marks byte 15.
- R6: When 0 < `alen_i` < 0xFF00, two bytes follow the first block: `alen_i[15:8]`, then `alen_i[7:0]`. The stream is 18 bytes long.
- R7: When `alen_i` >= 0xFF00, six bytes follow the first block: 0xFF, 0xFE, then `alen_i` as four big-endian octets. The stream is 22 bytes long.
- R8: A `start_i` seen while idle is accepted at that edge. `out_valid_o` rises in the next cycle with byte 0. One byte advances per edge where valid and ready are both high. After the edge that takes the last byte, valid and busy are low.
- R9: While `out_valid_o` is high and `out_ready_i` is low, `out_data_o`, `out_last_o` and `out_valid_o` hold, and no byte is skipped.
- R10: A `start_i` during a stream is ignored. The remaining bytes are still those of the accepted parameters.
- R11: While `rst_n` is low, `out_valid_o`, `err_o` and `busy_o` are low. This also holds when reset arrives in the middle of a stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Capture the parameters and begin (idle only) |
| tag_len_i | input | 5 | Tag length t in bytes (4..16, even) |
| q_len_i | input | 4 | Length-field size q in octets (2..8) |
| nonce_i | input | NONCE_BYTES*8 | Nonce; byte k at bits 8k+7:8k |
| plen_i | input | PLEN_W | Payload length in bytes |
| alen_i | input | 32 | Associated-data length in bytes |
| out_valid_o | output | 1 | Output byte valid |
| out_ready_i | input | 1 | Downstream accepts the byte |
| out_data_o | output | 8 | Output byte |
| out_last_o | output | 1 | Marks the final byte of the header |
| err_o | output | 1 | One-cycle payload-length overflow pulse |
| busy_o | output | 1 | A stream is in progress |

## Verification
The bench drives inputs on the falling edge and starts with `start_i`. The accepting rising edge is the only register stage before results appear. The bench therefore reads `err_o`, or `out_valid_o` with byte 0, at the next falling edge, one cycle after the stimulus. Each later byte is due one falling edge after the edge that consumed the previous byte. The bench models this by advancing its expected byte index only in cycles where it drove ready high. In stalled cycles it compares the held byte again. After the edge that takes the final byte, the bench checks at the following falling edge that valid and busy have dropped. For an overflow case, it checks one cycle later that the error pulse has cleared.

// File: rtl/ccm_hdr_pkg.sv
package ccm_hdr_pkg;
  localparam int BLK_BYTES   = 16;
  localparam int PFX_MAX     = 6;
  localparam int HDR_MAX     = BLK_BYTES + PFX_MAX;
  localparam int ALEN_W      = 32;
  localparam int IDX_W       = $clog2(HDR_MAX);
  localparam int CNT_W       = $clog2(PFX_MAX + 1);
  localparam logic [ALEN_W-1:0] SHORT_LIMIT = 32'h0000_FF00;

  typedef logic [7:0] byte_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SEND = 1'b1
  } fmt_state_e;
endpackage

// File: rtl/ccm_b0_build.sv
module ccm_b0_build
  import ccm_hdr_pkg::*;
#(
  parameter int NONCE_BYTES = 13,
  parameter int PLEN_W      = 64
) (
  input  logic [4:0]                      tag_len_i,
  input  logic [3:0]                      q_len_i,
  input  logic                            aad_nz_i,
  input  logic [NONCE_BYTES*8-1:0]        nonce_i,
  input  logic [PLEN_W-1:0]               plen_i,
  output logic [BLK_BYTES-1:0][7:0]       b0_o,
  output logic                            ovf_o
);
  localparam int LEN_MAX = 8;

  logic [63:0] plen_ext;
  logic [4:0]  tag_m2;
  logic [3:0]  q_m1;
  logic [6:0]  shamt;

  assign plen_ext = 64'(plen_i);
  assign tag_m2   = tag_len_i - 5'd2;
  assign q_m1     = q_len_i - 4'd1;
  assign shamt    = {q_len_i, 3'b000};

  // payload length must vanish once q octets are shifted away
  assign ovf_o = (plen_ext >> shamt) != 64'd0;

  for (genvar i = 0; i < BLK_BYTES; i++) begin : g_byte
    if (i == 0) begin : g_flags
      assign b0_o[i] = {1'b0, aad_nz_i, tag_m2[3:1], q_m1[2:0]};
    end else begin : g_body
      localparam int FROM_END = BLK_BYTES - 1 - i;
      byte_t len_byte;
      byte_t nonce_byte;
      if (FROM_END < LEN_MAX) begin : g_len
        assign len_byte = plen_ext[8*FROM_END +: 8];
      end else begin : g_nolen
        assign len_byte = 8'h00;
      end
      if (i - 1 < NONCE_BYTES) begin : g_nc
        assign nonce_byte = nonce_i[8*(i-1) +: 8];
      end else begin : g_nonc
        assign nonce_byte = 8'h00;
      end
      assign b0_o[i] = (4'(FROM_END) < q_len_i) ? len_byte : nonce_byte;
    end
  end
endmodule

// File: rtl/ccm_alen_encode.sv
module ccm_alen_encode
  import ccm_hdr_pkg::*;
(
  input  logic [ALEN_W-1:0]         alen_i,
  output logic [PFX_MAX-1:0][7:0]   pfx_o,
  output logic [CNT_W-1:0]          pfx_cnt_o
);
  always_comb begin
    pfx_o     = '0;
    pfx_cnt_o = '0;
    if (alen_i == '0) begin
      pfx_cnt_o = '0;
    end else if (alen_i < SHORT_LIMIT) begin
      pfx_cnt_o = CNT_W'(2);
      pfx_o[0]  = alen_i[15:8];
      pfx_o[1]  = alen_i[7:0];
    end else begin
      pfx_cnt_o = CNT_W'(6);
      pfx_o[0]  = 8'hFF;
      pfx_o[1]  = 8'hFE;
      pfx_o[2]  = alen_i[31:24];
      pfx_o[3]  = alen_i[23:16];
      pfx_o[4]  = alen_i[15:8];
      pfx_o[5]  = alen_i[7:0];
    end
  end
endmodule

// File: rtl/ccm_hdr_stream.sv
module ccm_hdr_stream
  import ccm_hdr_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start_i,
  input  logic                       ovf_i,
  input  logic [BLK_BYTES-1:0][7:0]  b0_i,
  input  logic [PFX_MAX-1:0][7:0]    pfx_i,
  input  logic [CNT_W-1:0]           pfx_cnt_i,
  input  logic                       ready_i,
  output logic                       valid_o,
  output logic [7:0]                 data_o,
  output logic                       last_o,
  output logic                       err_o,
  output logic                       busy_o
);
  fmt_state_e              st_q, st_d;
  logic [IDX_W-1:0]        idx_q, idx_d;
  logic [IDX_W-1:0]        total_q, total_d;
  logic                    err_q, err_d;
  logic                    load;
  logic [HDR_MAX-1:0][7:0] buf_q;
  logic                    at_end;

  assign at_end = (idx_q == total_q - IDX_W'(1));

  always_comb begin
    st_d    = st_q;
    idx_d   = idx_q;
    total_d = total_q;
    err_d   = 1'b0;
    load    = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          if (ovf_i) begin
            err_d = 1'b1;
          end else begin
            load    = 1'b1;
            st_d    = ST_SEND;
            idx_d   = '0;
            total_d = IDX_W'(BLK_BYTES) + IDX_W'(pfx_cnt_i);
          end
        end
      end
      ST_SEND: begin
        if (ready_i) begin
          if (at_end) st_d  = ST_IDLE;
          else        idx_d = idx_q + IDX_W'(1);
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      idx_q   <= '0;
      total_q <= '0;
      err_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      idx_q   <= idx_d;
      total_q <= total_d;
      err_q   <= err_d;
    end
  end

  // data register: no reset, loaded under an explicit enable
  always_ff @(posedge clk) begin
    if (load) begin
      buf_q <= {pfx_i, b0_i};
    end
  end

  assign valid_o = (st_q == ST_SEND);
  assign busy_o  = (st_q == ST_SEND);
  assign last_o  = valid_o && at_end;
  assign data_o  = buf_q[idx_q];
  assign err_o   = err_q;

  AST_FLAG_ADATA: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && idx_q == '0) |-> (data_o[7] == 1'b0 && data_o[6] == (total_q != IDX_W'(BLK_BYTES)))); // R1
  AST_ERR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> !valid_o); // R4
  AST_ERR_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> $past(start_i)); // R4
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready_i) |=> (valid_o && $stable(data_o) && $stable(last_o))); // R9
  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && ready_i && last_o) |=> !valid_o); // R8
  AST_LAST_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> valid_o); // R5
endmodule

// File: rtl/ccm_hdr_formatter.sv
module ccm_hdr_formatter
  import ccm_hdr_pkg::*;
#(
  parameter int NONCE_BYTES = 13,
  parameter int PLEN_W      = 64
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start_i,
  input  logic [4:0]                tag_len_i,
  input  logic [3:0]                q_len_i,
  input  logic [NONCE_BYTES*8-1:0]  nonce_i,
  input  logic [PLEN_W-1:0]         plen_i,
  input  logic [31:0]               alen_i,
  output logic                      out_valid_o,
  input  logic                      out_ready_i,
  output logic [7:0]                out_data_o,
  output logic                      out_last_o,
  output logic                      err_o,
  output logic                      busy_o
);
  logic [BLK_BYTES-1:0][7:0] b0;
  logic [PFX_MAX-1:0][7:0]   pfx;
  logic [CNT_W-1:0]          pfx_cnt;
  logic                      ovf;
  logic                      aad_nz;

  assign aad_nz = (alen_i != '0);

  ccm_b0_build #(
    .NONCE_BYTES(NONCE_BYTES),
    .PLEN_W     (PLEN_W)
  ) i_b0 (
    .tag_len_i(tag_len_i),
    .q_len_i  (q_len_i),
    .aad_nz_i (aad_nz),
    .nonce_i  (nonce_i),
    .plen_i   (plen_i),
    .b0_o     (b0),
    .ovf_o    (ovf)
  );

  ccm_alen_encode i_alen (
    .alen_i   (alen_i),
    .pfx_o    (pfx),
    .pfx_cnt_o(pfx_cnt)
  );

  ccm_hdr_stream i_stream (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .ovf_i    (ovf),
    .b0_i     (b0),
    .pfx_i    (pfx),
    .pfx_cnt_i(pfx_cnt),
    .ready_i  (out_ready_i),
    .valid_o  (out_valid_o),
    .data_o   (out_data_o),
    .last_o   (out_last_o),
    .err_o    (err_o),
    .busy_o   (busy_o)
  );
endmodule

// File: tb/test_ccm_hdr_formatter.sv
module test_ccm_hdr_formatter;
  localparam int NB = 13;
  localparam int PW = 64;

  typedef struct packed {
    logic [4:0]  t;
    logic [3:0]  q;
    logic [31:0] a;
    logic [63:0] p;
    logic [4:0]  cnt;
    logic        err;
    logic [3:0]  pat;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{5'd16, 4'd2, 32'h0,          64'h1234,                5'd16, 1'b0, 4'hF},
    '{5'd8,  4'd3, 32'h20,         64'h0ABCDE,              5'd18, 1'b0, 4'h5},
    '{5'd4,  4'd8, 32'hFEFF,       64'h0102030405060708,    5'd18, 1'b0, 4'h9},
    '{5'd12, 4'd4, 32'hFF00,       64'hDEADBEEF,            5'd22, 1'b0, 4'hE},
    '{5'd10, 4'd2, 32'h1,          64'hFFFF,                5'd18, 1'b0, 4'h3},
    '{5'd6,  4'd2, 32'h0,          64'h10000,               5'd0,  1'b1, 4'hF},
    '{5'd14, 4'd7, 32'hFFFFFFFF,   64'h00FFFFFFFFFFFFFF,    5'd22, 1'b0, 4'h7},
    '{5'd16, 4'd7, 32'h0,          64'h0100000000000000,    5'd0,  1'b1, 4'hF}
  };

  logic          clk;
  logic          rst_n;
  logic          start_i;
  logic [4:0]    tag_len_i;
  logic [3:0]    q_len_i;
  logic [NB*8-1:0] nonce_i;
  logic [PW-1:0] plen_i;
  logic [31:0]   alen_i;
  logic          out_valid_o;
  logic          out_ready_i;
  logic [7:0]    out_data_o;
  logic          out_last_o;
  logic          err_o;
  logic          busy_o;

  int n_chk;
  int n_bad;
  logic [NB*8-1:0] nonce_ref;

  ccm_hdr_formatter #(.NONCE_BYTES(NB), .PLEN_W(PW)) i_ccm_hdr_formatter (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .tag_len_i  (tag_len_i),
    .q_len_i    (q_len_i),
    .nonce_i    (nonce_i),
    .plen_i     (plen_i),
    .alen_i     (alen_i),
    .out_valid_o(out_valid_o),
    .out_ready_i(out_ready_i),
    .out_data_o (out_data_o),
    .out_last_o (out_last_o),
    .err_o      (err_o),
    .busy_o     (busy_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [21:0][7:0] model(input vec_t v, input logic [NB*8-1:0] nc);
    logic [21:0][7:0] e;
    int q;
    q = int'(v.q);
    e = '0;
    e[0] = {1'b0, (v.a != 0), 3'((int'(v.t) - 2) / 2), 3'(q - 1)};   // R1
    for (int i = 1; i < 16; i++) begin
      if (i <= 15 - q) e[i] = nc[8*(i-1) +: 8];                      // R2
      else             e[i] = 8'(v.p >> (8 * (15 - i)));              // R3
    end
    if (v.a != 0 && v.a < 32'hFF00) begin                              // R6
      e[16] = v.a[15:8];
      e[17] = v.a[7:0];
    end else if (v.a != 0) begin                                        // R7
      e[16] = 8'hFF;
      e[17] = 8'hFE;
      e[18] = v.a[31:24];
      e[19] = v.a[23:16];
      e[20] = v.a[15:8];
      e[21] = v.a[7:0];
    end
    return e;
  endfunction

  task automatic run_case(input vec_t v, input bit poke);
    logic [21:0][7:0] e;
    int n;
    int cyc;
    bit stalled;
    logic [7:0] held;
    e = model(v, nonce_ref);
    @(negedge clk);
    tag_len_i = v.t; q_len_i = v.q; alen_i = v.a; plen_i = v.p;
    nonce_i = nonce_ref; start_i = 1'b1; out_ready_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
    check(err_o == v.err, "R4 err pulse", 64'(err_o), 64'(v.err));
    if (v.err) begin
      check(!out_valid_o && !busy_o, "R4 no output on overflow", 64'(out_valid_o), 64'd0);
      @(negedge clk);
      check(!err_o && !out_valid_o, "R4 single-cycle error", 64'(err_o), 64'd0);
      return;
    end
    n = 0; cyc = 0; stalled = 1'b0; held = '0;
    while (n < int'(v.cnt) && cyc < 400) begin
      check(out_valid_o, "R8 valid while streaming", 64'(out_valid_o), 64'd1);
      if (stalled) check(out_data_o == held, "R9 byte held under stall", 64'(out_data_o), 64'(held));
      check(out_data_o == e[n], (n == 0) ? "R1 flags byte" : (n < 16) ? "R2/R3 block byte" :
            (v.cnt == 5'd18) ? "R6 short length byte" : "R7 long length byte",
            64'(out_data_o), 64'(e[n]));
      check(out_last_o == (n == int'(v.cnt) - 1), (v.cnt == 5'd16) ? "R5 last marker" : "R8 last marker",
            64'(out_last_o), 64'(n == int'(v.cnt) - 1));
      out_ready_i = v.pat[cyc % 4];
      if (poke && cyc == 2) begin
        // R10: a start during a stream must not disturb it
        start_i = 1'b1; tag_len_i = 5'd4; q_len_i = 4'd8; alen_i = 32'h0;
        plen_i = 64'h5; nonce_i = ~nonce_ref;
      end
      if (out_ready_i) begin n++; stalled = 1'b0; end
      else begin stalled = 1'b1; held = out_data_o; end
      @(negedge clk);
      start_i = 1'b0;
      cyc++;
    end
    out_ready_i = 1'b0;
    check(n == int'(v.cnt), poke ? "R10 stream completed" : "R8 stream completed", 64'(n), 64'(v.cnt));
    check(!out_valid_o && !busy_o, "R8 idle after last byte", 64'(out_valid_o), 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    n_chk = 0; n_bad = 0;
    for (int k = 0; k < NB; k++) nonce_ref[8*k +: 8] = 8'hA0 + 8'(k);
    rst_n = 1'b0; start_i = 1'b0; out_ready_i = 1'b0;
    tag_len_i = '0; q_len_i = 4'd2; nonce_i = '0; plen_i = '0; alen_i = '0;
    repeat (3) @(negedge clk);
    check(!out_valid_o && !err_o && !busy_o, "R11 reset state", 64'({out_valid_o, err_o, busy_o}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) run_case(VECS[i], 1'b0);

    // directed: start ignored while busy
    run_case(VECS[3], 1'b1);
    run_case(VECS[1], 1'b1);

    // directed: reset in the middle of a stream
    @(negedge clk);
    tag_len_i = 5'd8; q_len_i = 4'd3; alen_i = 32'h20; plen_i = 64'h77;
    nonce_i = nonce_ref; start_i = 1'b1; out_ready_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (3) @(negedge clk);
    check(busy_o, "R11 stream active before reset", 64'(busy_o), 64'd1);
    rst_n = 1'b0;
    #1;
    check(!out_valid_o && !busy_o && !err_o, "R11 reset mid-stream", 64'({out_valid_o, busy_o, err_o}), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    out_ready_i = 1'b0;
    @(negedge clk);
    check(!out_valid_o, "R11 idle after reset release", 64'(out_valid_o), 64'd0);

    // directed: back-to-back after reset still works
    run_case(VECS[0], 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule